// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned binary operands and a carry-in. It returns the sum and a carry-out, and it has no clock. The default width is 16 bits, split into four slices of 4 bits.

Each bit position forms two terms: a generate term, the AND of its operand bits, and a propagate term, the XOR of its operand bits. Within a slice, every internal carry is a flat sum-of-products of those bit terms and the slice carry-in. The slice also reports a slice generate and a slice propagate. A second-level lookahead unit with the same structure takes the slice terms and the external carry-in. From them it forms the carry into every slice and the final carry-out. No carry ripples from bit to bit, and no carry ripples from slice to slice. The bit count in each lookahead term is kept at the slice width, so that gate fan-in stays small.

The adder is used as a plain combinational datapath element. Registers at its ports, if any, belong to the surrounding logic.

Top module: `cla_adder16`

## Requirements
- R1: `{carry_o, sum_o}` equals the full-width unsigned sum `a_i + b_i + carry_i`, for every operand pair and both carry-in values.
- R2: With `a_i ^ b_i` all ones and `carry_i` = 1, the carry crosses every slice: `sum_o` is 0 and `carry_o` is 1 (for example 0xFFFF + 0x0000 + 1).
- R3: All ones plus all ones with `carry_i` = 0 gives `sum_o` = 0xFFFE and `carry_o` = 1. With `carry_i` = 1 it gives 0xFFFF and 1.
- R4: Zero plus zero gives `sum_o` = `carry_i` in bit 0, all other bits 0, and `carry_o` = 0.
- R5: The carry into slice k+1, formed by the second-level unit, equals the carry out of slice k. This carry is set exactly when slice k's generate is set, or when its propagate is set and its carry-in is set. Slice boundaries are at bits 4, 8 and 12, so 0x00FF + 0x0001 gives 0x0100.
- R6: A slice's propagate is 1 exactly when `a_i` and `b_i` differ in all four of its bits. So 0xAAAA + 0x5555 gives 0xFFFF with carry 0 when `carry_i` = 0, and 0x0000 with carry 1 when `carry_i` = 1.
- R7: A slice's generate is 1 exactly when the 4-bit slice sum of `a_i` and `b_i`, taken with no carry-in, overflows. The second-level generate and propagate predict `carry_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand, unsigned |
| b_i | input | 16 | Second operand, unsigned |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
Bound assertions re-evaluate whenever an operand changes. They compare the full sum against arithmetic (R1), and the carries the second-level unit forms against the carry-out of each slice (R5). They also compare each slice's propagate and generate against slice-local arithmetic (R6, R7), and check the whole-word propagate case (R2). The corner operands come only from the bench's directed scenarios: all ones, zero, alternating patterns and carries across slice boundaries, each with both carry-in values (R2–R4, R6). The random scenarios exercise R1 over a wide operand spread.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DEF_GROUP_W  = 4;
  localparam int unsigned DEF_N_GROUPS = 4;
endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g_o[i] = a_i[i] & b_i[i];
    assign p_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/cla_lookahead.sv
// Flat lookahead: every carry is one sum-of-products over the inputs.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         c_i,
  output logic [N:0]   c_o,
  output logic         gg_o,
  output logic         gp_o
);
  always_comb begin
    c_o[0] = c_i;
    for (int j = 1; j <= N; j++) begin
      logic acc;
      acc = c_i;
      for (int k = 0; k < j; k++) acc = acc & p_i[k];
      for (int i = 0; i < j; i++) begin
        logic t;
        t = g_i[i];
        for (int k = i + 1; k < j; k++) t = t & p_i[k];
        acc = acc | t;
      end
      c_o[j] = acc;
    end
  end

  always_comb begin
    gg_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic t;
      t = g_i[i];
      for (int k = i + 1; k < N; k++) t = t & p_i[k];
      gg_o = gg_o | t;
    end
  end

  assign gp_o = &p_i;
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o,
  output logic         gg_o,
  output logic         gp_o
);
  logic [W-1:0] g_w, p_w;
  logic [W:0]   c_w;

  cla_pg_cell #(.W(W)) u_pg (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (g_w),
    .p_o (p_w)
  );

  cla_lookahead #(.N(W)) u_la (
    .g_i  (g_w),
    .p_i  (p_w),
    .c_i  (c_i),
    .c_o  (c_w),
    .gg_o (gg_o),
    .gp_o (gp_o)
  );

  assign s_o = p_w ^ c_w[W-1:0];
  assign c_o = c_w[W];
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int unsigned GROUP_W  = DEF_GROUP_W,
  parameter int unsigned N_GROUPS = DEF_N_GROUPS,
  localparam int unsigned WIDTH   = GROUP_W * N_GROUPS
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  logic [N_GROUPS-1:0] grp_g, grp_p, grp_cout;
  logic [N_GROUPS:0]   grp_c;
  logic                lvl2_gg, lvl2_gp;

  for (genvar k = 0; k < N_GROUPS; k++) begin : g_grp
    cla_group #(.W(GROUP_W)) u_grp (
      .a_i  (a_i[k*GROUP_W +: GROUP_W]),
      .b_i  (b_i[k*GROUP_W +: GROUP_W]),
      .c_i  (grp_c[k]),
      .s_o  (sum_o[k*GROUP_W +: GROUP_W]),
      .c_o  (grp_cout[k]),
      .gg_o (grp_g[k]),
      .gp_o (grp_p[k])
    );
  end

  // second level: slice carries straight from slice g/p and carry_i
  cla_lookahead #(.N(N_GROUPS)) u_lvl2 (
    .g_i  (grp_g),
    .p_i  (grp_p),
    .c_i  (carry_i),
    .c_o  (grp_c),
    .gg_o (lvl2_gg),
    .gp_o (lvl2_gp)
  );

  assign carry_o = grp_c[N_GROUPS];
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int unsigned GROUP_W  = 4,
  parameter int unsigned N_GROUPS = 4,
  localparam int unsigned WIDTH   = GROUP_W * N_GROUPS
) (
  input logic [WIDTH-1:0]    a_i,
  input logic [WIDTH-1:0]    b_i,
  input logic                carry_i,
  input logic [WIDTH-1:0]    sum_o,
  input logic                carry_o,
  input logic [N_GROUPS-1:0] grp_g,
  input logic [N_GROUPS-1:0] grp_p,
  input logic [N_GROUPS-1:0] grp_cout,
  input logic [N_GROUPS:0]   grp_c,
  input logic                lvl2_gg,
  input logic                lvl2_gp
);
  logic known;
  assign known = !$isunknown({a_i, b_i, carry_i});

  always_comb begin
    if (known) begin
      // R1
      sum_arith_chk: assert ({carry_o, sum_o} ==
                             ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}));
      // R2
      full_prop_chk: assert (!(carry_i && (&(a_i ^ b_i))) || (sum_o == '0 && carry_o));
      // R7
      lvl2_cout_chk: assert (carry_o == (lvl2_gg | (lvl2_gp & carry_i)));
    end
  end

  for (genvar k = 0; k < N_GROUPS; k++) begin : g_chk
    logic [GROUP_W:0] slice_sum;
    assign slice_sum = {1'b0, a_i[k*GROUP_W +: GROUP_W]} + {1'b0, b_i[k*GROUP_W +: GROUP_W]};
    always_comb begin
      if (known) begin
        // R5
        grp_carry_chk: assert (grp_c[k+1] == grp_cout[k]);
        // R6
        grp_prop_chk: assert (grp_p[k] == &(a_i[k*GROUP_W +: GROUP_W] ^ b_i[k*GROUP_W +: GROUP_W]));
        // R7
        grp_gen_chk: assert (grp_g[k] == slice_sum[GROUP_W]);
      end
    end
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.GROUP_W(GROUP_W), .N_GROUPS(N_GROUPS)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .carry_i  (carry_i),
  .sum_o    (sum_o),
  .carry_o  (carry_o),
  .grp_g    (grp_g),
  .grp_p    (grp_p),
  .grp_cout (grp_cout),
  .grp_c    (grp_c),
  .lvl2_gg  (lvl2_gg),
  .lvl2_gp  (lvl2_gp)
);

// File: tb/cla_adder16_bench.sv
module cla_adder16_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct {
    logic [W:0] exp;
    string      req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         carry_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         carry_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cla_adder16 u_cla_adder16 (
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .sum_o   (sum_o),
    .carry_o (carry_o)
  );

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input string req);
    item_t it;
    @(posedge clk);
    a_i = a; b_i = b; carry_i = ci;
    it.exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: results settle within the cycle, compare on the falling edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if ({carry_o, sum_o} !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got carry=%0b sum=%h, expected carry=%0b sum=%h",
                 it.req, carry_o, sum_o, it.exp[W], it.exp[W-1:0]);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R4 zero operands
    drive(16'h0000, 16'h0000, 1'b0, "R4");
    drive(16'h0000, 16'h0000, 1'b1, "R4");
    // R2 carry through all slices
    drive(16'hFFFF, 16'h0000, 1'b1, "R2");
    drive(16'h0000, 16'hFFFF, 1'b1, "R2");
    drive(16'hFFFF, 16'h0001, 1'b0, "R2");
    // R3 all ones
    drive(16'hFFFF, 16'hFFFF, 1'b0, "R3");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R3");
    // R6 alternating patterns
    drive(16'hAAAA, 16'h5555, 1'b0, "R6");
    drive(16'hAAAA, 16'h5555, 1'b1, "R6");
    drive(16'hAAAA, 16'hAAAA, 1'b0, "R6");
    drive(16'h5555, 16'h5555, 1'b1, "R6");
    // R5 carries across each slice boundary
    drive(16'h000F, 16'h0001, 1'b0, "R5");
    drive(16'h00FF, 16'h0001, 1'b0, "R5");
    drive(16'h0FFF, 16'h0000, 1'b1, "R5");
    drive(16'hF0F0, 16'h0F10, 1'b0, "R5");
    drive(16'h0F0F, 16'h00F1, 1'b0, "R5");
    // R7 slice generate without propagate chain
    drive(16'h8888, 16'h8888, 1'b0, "R7");
    drive(16'h0008, 16'h0008, 1'b1, "R7");
    // R1 random operands
    for (int i = 0; i < 400; i++)
      drive(W'($urandom), W'($urandom), 1'($urandom), "R1");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule